// File: doc/BRIEF.md
# Dual PDM Microphone Receiver

This block drives the bit clock for two pulse-density-modulated microphones that share one data wire and takes in both bit streams. One microphone puts its bit on the wire while the clock is low, and the block takes that bit when the clock rises. The other microphone drives the wire while the clock is high, and the block takes that bit when the clock falls. No word-select or frame-sync signal exists. Each data line carries only the clock and the data.

The block packs sixteen consecutive bits from each microphone into one 32-bit word and places that word in a receive holding register. The holding register has a ready flag and a sticky overrun flag. The bit clock comes from the system clock through a programmable integer divider. A typical setting is 64 times the output sample rate, for example 3.072 MHz for 48 kHz audio. Decimation and PCM conversion are done downstream.

Top module: `pdm_pair_rx`

## Requirements
- R1: `pdm_clk` is low during reset and in every cycle after a system clock edge at which `enable` was low.
- R2: While enabled, each high and each low level of `pdm_clk` lasts exactly `max(div_half,1)` system clock cycles.
- R3: The bit on `pdm_dat` at a rising transition of `pdm_clk` belongs to the left microphone. The bit at a falling transition belongs to the right microphone.
- R4: In a completed word, the left bits occupy [15:0] and the right bits occupy [31:16]. In each half, the earliest bit is at the least significant position.
- R5: A word completes on the 16th falling transition after enable. `rx_valid` and the new `rx_word` appear one system cycle after that transition.
- R6: `rx_valid` clears one cycle after `rx_ack` is high, unless a new word lands in that same cycle. `rx_word` changes only when a new word lands.
- R7: If `rx_ack` is high in the cycle a new word lands, the new word is loaded, `rx_valid` stays high and `rx_overrun` is not set.
- R8: If a word lands while `rx_valid` is high and `rx_ack` is low, `rx_overrun` sets and the new word replaces the old one.
- R9: `rx_overrun` stays high until `ovr_clr` is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R10: Dropping `enable` discards any partial word. After re-enable, bit and pair counting start afresh and no word lands while the block is disabled.
- R11: After reset, `rx_valid` is 0, `rx_overrun` is 0 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the bit clock and capture when high |
| div_half | input | DIV_W | System cycles per bit-clock half period (0 acts as 1) |
| pdm_clk | output | 1 | Bit clock to both microphones |
| pdm_dat | input | 1 | Shared microphone data line |
| rx_word | output | 32 | Holding register: right bits [31:16], left bits [15:0] |
| rx_valid | output | 1 | Receive-ready flag |
| rx_ack | input | 1 | Read acknowledge, clears `rx_valid` |
| rx_overrun | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears `rx_overrun` |

## Verification
The hardest cases to reach from the ports are the two same-cycle collisions: an acknowledge in the very cycle a new word lands, and an overrun clear in the very cycle a collision sets the flag. The bench reaches both by watching the bit clock at each falling system edge. When its own model sees the falling transition that completes a word, it drives `rx_ack` or `ovr_clr` at that moment, so the pulse meets the word's arrival in the holding register. The bench also switches the divider between runs, down to one cycle per half period. It drops `enable` in the middle of a word to check that partial words are discarded.

// File: rtl/pdm_pair_pkg.sv
package pdm_pair_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // right microphone in the upper half, left in the lower half
  function automatic word_t pack_pair(input half_t left_bits, input half_t right_bits);
    return {right_bits, left_bits};
  endfunction

  // shift a new bit in at the top so the first bit ends at position 0
  function automatic half_t push_bit(input half_t sr, input logic b);
    return {b, sr[HALF_W-1:1]};
  endfunction
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_half,
  output logic             pdm_clk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim_m1;
  logic             wrap;

  assign lim_m1   = (div_half == '0) ? '0 : div_half - 1'b1;
  assign wrap     = enable && (cnt == lim_m1);
  assign rise_evt = wrap && !pdm_clk;
  assign fall_evt = wrap && pdm_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (!enable) begin
      cnt     <= '0;
      pdm_clk <= 1'b0;
    end else if (wrap) begin
      cnt     <= '0;
      pdm_clk <= ~pdm_clk;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdm_pair_shifter.sv
module pdm_pair_shifter
  import pdm_pair_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  logic  pdm_dat,
  input  logic  rise_evt,
  input  logic  fall_evt,
  output logic  word_done,
  output word_t word_out
);
  localparam int unsigned CNT_W = $clog2(HALF_W);

  half_t            left_sr;
  half_t            right_sr;
  logic [CNT_W-1:0] pair_cnt;
  logic             last_pair;

  assign last_pair = fall_evt && (pair_cnt == CNT_W'(HALF_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_sr   <= '0;
      right_sr  <= '0;
      pair_cnt  <= '0;
      word_done <= 1'b0;
      word_out  <= '0;
    end else begin
      word_done <= 1'b0;
      if (!enable) begin
        pair_cnt <= '0;
      end else begin
        if (rise_evt) left_sr <= push_bit(left_sr, pdm_dat);
        if (fall_evt) begin
          right_sr <= push_bit(right_sr, pdm_dat);
          pair_cnt <= last_pair ? '0 : pair_cnt + 1'b1;
        end
        if (last_pair) begin
          word_done <= 1'b1;
          word_out  <= pack_pair(left_sr, push_bit(right_sr, pdm_dat));
        end
      end
    end
  end
endmodule

// File: rtl/pdm_rx_hold.sv
module pdm_rx_hold
  import pdm_pair_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_done,
  input  word_t word_in,
  input  logic  rx_ack,
  input  logic  ovr_clr,
  output word_t rx_word,
  output logic  rx_valid,
  output logic  rx_overrun
);
  logic collide;

  assign collide = word_done && rx_valid && !rx_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word    <= '0;
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (word_done) begin
        rx_word  <= word_in;
        rx_valid <= 1'b1;
      end else if (rx_ack) begin
        rx_valid <= 1'b0;
      end
      if (collide)      rx_overrun <= 1'b1;
      else if (ovr_clr) rx_overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/pdm_pair_rx.sv
module pdm_pair_rx
  import pdm_pair_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_half,
  output logic             pdm_clk,
  input  logic             pdm_dat,
  output logic [31:0]      rx_word,
  output logic             rx_valid,
  input  logic             rx_ack,
  output logic             rx_overrun,
  input  logic             ovr_clr
);
  logic  rise_evt;
  logic  fall_evt;
  logic  word_done;
  word_t word_bus;
  word_t hold_word;

  pdm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .div_half (div_half),
    .pdm_clk  (pdm_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  pdm_pair_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .pdm_dat   (pdm_dat),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .word_done (word_done),
    .word_out  (word_bus)
  );

  pdm_rx_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_done  (word_done),
    .word_in    (word_bus),
    .rx_ack     (rx_ack),
    .ovr_clr    (ovr_clr),
    .rx_word    (hold_word),
    .rx_valid   (rx_valid),
    .rx_overrun (rx_overrun)
  );

  assign rx_word = hold_word;
endmodule

// File: rtl/pdm_pair_rx_chk.sv
module pdm_pair_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        pdm_clk,
  input logic        rise_evt,
  input logic        fall_evt,
  input logic        word_done,
  input logic [31:0] rx_word,
  input logic        rx_valid,
  input logic        rx_ack,
  input logic        rx_overrun,
  input logic        ovr_clr
);
  // R1
  clk_low_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pdm_clk);

  // R3
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));

  // R5
  ready_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_valid);

  // R6
  word_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(rx_word));

  // R7
  ack_collide_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_ack && !rx_overrun && ovr_clr == 1'b0) |=> !rx_overrun);

  // R8
  overrun_on_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_valid && !rx_ack) |=> rx_overrun);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !ovr_clr) |=> rx_overrun);

  // R10
  no_word_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !word_done);
endmodule

bind pdm_pair_rx pdm_pair_rx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .pdm_clk    (pdm_clk),
  .rise_evt   (rise_evt),
  .fall_evt   (fall_evt),
  .word_done  (word_done),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid),
  .rx_ack     (rx_ack),
  .rx_overrun (rx_overrun),
  .ovr_clr    (ovr_clr)
);

// File: tb/tb_pdm_pair_rx.sv
module tb_pdm_pair_rx;
  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [DW-1:0] div_half = 8'd3;
  logic          pdm_clk;
  logic          pdm_dat = 1'b0;
  logic [31:0]   rx_word;
  logic          rx_valid;
  logic          rx_ack = 1'b0;
  logic          rx_overrun;
  logic          ovr_clr = 1'b0;

  pdm_pair_rx #(.DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_half(div_half),
    .pdm_clk(pdm_clk), .pdm_dat(pdm_dat), .rx_word(rx_word),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_overrun(rx_overrun),
    .ovr_clr(ovr_clr)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // scenario controls, written by the sequencer at rising edges
  bit en_want = 0;
  int ack_mode = 0;   // 0 never, 1 when ready seen, 2 in the landing cycle
  int data_mode = 0;  // 0 pseudo-random, 1 level-derived pattern
  bit clr_req = 0;
  bit clr_arm = 0;
  bit reset_checked = 0;

  // reference model state
  bit          m_valid = 0;
  bit          m_ovr = 0;
  logic [31:0] m_word = '0;
  bit          pend = 0;
  logic [31:0] pend_word = '0;
  bit          lq[$];
  bit          rq[$];
  bit          en_q = 0, ack_q = 0, clr_q = 0, dat_q = 0;
  bit          prev_clk = 0;
  int          run_len = 0;
  bit          run_ok = 0;
  int          words_seen = 0;
  int          cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog R5 act=%0d exp=%0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (!rst_n) begin
      if (!reset_checked) begin
        reset_checked = 1;
        check(rx_valid == 0, "R11 valid", 32'(rx_valid), 0);
        check(rx_overrun == 0, "R11 overrun", 32'(rx_overrun), 0);
        check(rx_word == 0, "R11 word", rx_word, 0);
        check(pdm_clk == 0, "R1 clk in reset", 32'(pdm_clk), 0);
      end
    end else begin
      // 1: holding register update for the edge just passed
      if (pend) begin
        if (m_valid && !ack_q) m_ovr = 1;
        else if (clr_q) m_ovr = 0;
        m_word = pend_word;
        m_valid = 1;
        words_seen++;
      end else begin
        if (ack_q) m_valid = 0;
        if (clr_q) m_ovr = 0;
      end
      pend = 0;
      // 2: compare
      check(rx_valid == m_valid, "R5/R6/R7 ready", 32'(rx_valid), 32'(m_valid));
      check(rx_overrun == m_ovr, "R8/R9 overrun", 32'(rx_overrun), 32'(m_ovr));
      check(rx_word == m_word, "R3/R4 word", rx_word, m_word);
      if (!en_q) check(pdm_clk == 0, "R1 clk low when off", 32'(pdm_clk), 0);
      // 3: bit-clock observation and capture
      if (!en_q) begin
        lq.delete(); rq.delete();
        run_ok = 0; run_len = 0;
      end else begin
        if (pdm_clk != prev_clk) begin
          if (run_ok)
            check(run_len == ((div_half == 0) ? 1 : int'(div_half)), "R2 half period",
                  32'(run_len), 32'((div_half == 0) ? 1 : int'(div_half)));
          run_ok = 1; run_len = 1;
          if (pdm_clk) lq.push_back(dat_q);
          else begin
            rq.push_back(dat_q);
            if (rq.size() == 16) begin
              for (int i = 0; i < 16; i++) begin
                pend_word[i]      = lq[i];
                pend_word[16 + i] = rq[i];
              end
              pend = 1;
              lq.delete(); rq.delete();
            end
          end
        end else begin
          run_len++;
        end
      end
      prev_clk = pdm_clk;
      // 4: drive inputs for the next edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dat_q = (data_mode == 1) ? !pdm_clk : lfsr[0];
      case (ack_mode)
        1:       ack_q = m_valid;
        2:       ack_q = pend && m_valid;
        default: ack_q = 0;
      endcase
      clr_q = 0;
      if (clr_req) begin clr_q = 1; clr_req = 0; end
      else if (clr_arm && pend && m_valid) begin clr_q = 1; clr_arm = 0; end
      en_q = en_want;
      pdm_dat = dat_q;
      rx_ack  = ack_q;
      ovr_clr = clr_q;
      enable  = en_q;
    end
  end

  task automatic wait_words(input int n);
    int target;
    target = words_seen + n;
    while (words_seen < target) @(posedge clk);
  endtask

  task automatic restart(input logic [DW-1:0] d);
    en_want = 0;
    repeat (4) @(posedge clk);
    div_half = d;
    en_want = 1;
  endtask

  initial begin
    #(CLK_P * 4 + CLK_P / 4) rst_n = 1'b1;
    // random data, prompt reads (R3, R4, R5, R6)
    ack_mode = 1;
    restart(8'd3);
    wait_words(3);
    // level-derived pattern: left bits all 1, right bits all 0 (R4)
    data_mode = 1;
    wait_words(2);
    @(negedge clk); #1;
    check(rx_word == 32'h0000FFFF, "R4 pattern", rx_word, 32'h0000FFFF);
    data_mode = 0;
    // fastest divider, no reads: overrun (R8), then clear (R9)
    ack_mode = 0;
    restart(8'd1);
    wait_words(3);
    @(negedge clk); #1;
    check(rx_overrun == 1, "R8 overrun set", 32'(rx_overrun), 1);
    @(posedge clk); clr_req = 1;
    repeat (3) @(posedge clk);
    // zero divider acts as one, acknowledge in the landing cycle (R7)
    ack_mode = 2;
    restart(8'd0);
    wait_words(4);
    @(negedge clk); #1;
    check(rx_overrun == 0, "R7 no overrun", 32'(rx_overrun), 0);
    check(rx_valid == 1, "R7 ready kept", 32'(rx_valid), 1);
    // set beats clear (R9)
    ack_mode = 0;
    wait_words(1);
    @(posedge clk); clr_req = 1;
    repeat (3) @(posedge clk);
    clr_arm = 1;
    while (clr_arm) @(posedge clk);
    repeat (3) @(negedge clk); #1;
    check(rx_overrun == 1, "R9 set wins", 32'(rx_overrun), 1);
    @(posedge clk); clr_req = 1;
    // disable mid-word, restart with another divider (R10)
    ack_mode = 1;
    restart(8'd5);
    wait_words(1);
    repeat (40) @(posedge clk);
    en_want = 0;
    repeat (30) @(negedge clk);
    #1;
    check(rx_valid == 0, "R10 no word while off", 32'(rx_valid), 0);
    @(posedge clk);
    en_want = 1;
    wait_words(2);
    repeat (4) @(posedge clk);
    check(words_seen >= 15, "R5 words landed", 32'(words_seen), 15);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule